// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a one-cycle write request from synchronous logic into a properly ordered write cycle on an asynchronous 16K x 4 static RAM whose data pins are a shared bidirectional bus. The request carries a 14-bit address and a 4-bit data word. While the block is idle it accepts a request, latches the address and data, and then walks a fixed sequence of phases. Each phase is a parameter counted in system clocks: address setup, write-enable lead, select/enable overlap, and recovery.

The order of the control edges is the point of the design. Write enable falls first and chip select falls some clocks later, so the RAM never turns its outputs on during the write. The block drives the data bus only while both strobes are low. It releases the bus on the same clock edge that ends the write. Every memory-side output comes from a flop. When recovery is over, a done strobe is high for one clock. A request that arrives while a write is in progress is dropped.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted, mem_cs_n and mem_we_n are 1, mem_doe is 0 and wr_done is 0. An asserted reset takes effect at once, even in the middle of a write.
- R2: When wr_req is sampled high in idle, mem_addr and mem_dout take the request's address and data on that same clock edge. Both keep those values until the clock in which wr_done is high.
- R3: Write enable (mem_we_n = 0) falls AS_CYC clocks after the accepting edge. mem_cs_n stays 1 during those setup clocks.
- R4: Chip select falls DRV_CYC clocks after write enable falls. mem_cs_n is never 0 while mem_we_n is 1.
- R5: The overlap, with both strobes at 0, lasts exactly WP_CYC clocks. The two strobes return to 1 on the same edge, and the RAM latches the address and data present at that edge.
- R6: mem_doe is 1 exactly during the overlap. The bus is never driven while the RAM could be driving it, which is any time chip select is low and write enable is high.
- R7: After the end of the write, the address holds for WR_CYC recovery clocks. wr_done is then 1 for exactly one clock, and the block is idle again in that same clock.
- R8: A wr_req raised during a write is ignored. It changes neither the address, the data nor the timing of the write in progress.
- R9: Valid data is driven for at least DV_CYC clocks before the end of the write. This requires WP_CYC >= DV_CYC.
- R10: A request presented in the clock where wr_done is high is accepted with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_req | input | 1 | One-cycle write request, sampled only when idle |
| wr_addr | input | 14 | Write address |
| wr_data | input | 4 | Write data |
| wr_done | output | 1 | One-clock pulse when the write cycle and its recovery have finished |
| mem_addr | output | 14 | RAM address bus |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dout | output | 4 | Value for the shared data bus |
| mem_doe | output | 1 | Drive enable for the shared data bus |

## Verification
The assertions take for granted that the timing parameters are at least one and that WP_CYC is no smaller than DV_CYC. They also assume that a reset only ever happens with an asynchronous assertion followed by a clean release. The stimulus keeps the default parameters. It holds each request for one clock, except for deliberate requests made while a write is busy. It drives inputs only half a cycle away from the active edge. The bench includes a small RAM model that flags bus contention and captures the word written at the end of each overlap.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LEAD  = 3'd2,
    PH_PULSE = 3'd3,
    PH_RECOV = 3'd4
  } phase_t;
endpackage

// File: rtl/sws_timer.sv
module sws_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sws_fsm.sv
module sws_fsm
  import sws_pkg::*;
#(
  parameter int AS_CYC  = 1,
  parameter int DRV_CYC = 1,
  parameter int WP_CYC  = 2,
  parameter int WR_CYC  = 1,
  parameter int CW      = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  output phase_t phase_nxt,
  output logic   accept,
  output logic   done_nxt
);
  phase_t        phase_q;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          last;

  sws_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .last     (last)
  );

  always_comb begin
    phase_nxt = phase_q;
    ld        = 1'b0;
    ld_val    = '0;
    accept    = 1'b0;
    done_nxt  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req) begin
        phase_nxt = PH_SETUP;
        ld        = 1'b1;
        ld_val    = CW'(AS_CYC - 1);
        accept    = 1'b1;
      end
      PH_SETUP: if (last) begin
        phase_nxt = PH_LEAD;
        ld        = 1'b1;
        ld_val    = CW'(DRV_CYC - 1);
      end
      PH_LEAD: if (last) begin
        phase_nxt = PH_PULSE;
        ld        = 1'b1;
        ld_val    = CW'(WP_CYC - 1);
      end
      PH_PULSE: if (last) begin
        phase_nxt = PH_RECOV;
        ld        = 1'b1;
        ld_val    = CW'(WR_CYC - 1);
      end
      PH_RECOV: if (last) begin
        phase_nxt = PH_IDLE;
        done_nxt  = 1'b1;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nxt;
  end
endmodule

// File: rtl/sws_outreg.sv
module sws_outreg
  import sws_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  phase_t        phase_nxt,
  input  logic          done_nxt,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_doe,
  output logic          done
);
  logic cs_n_d, we_n_d, doe_d;

  always_comb begin
    we_n_d = !((phase_nxt == PH_LEAD) || (phase_nxt == PH_PULSE));
    cs_n_d = (phase_nxt != PH_PULSE);
    doe_d  = (phase_nxt == PH_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dout <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_doe  <= 1'b0;
      done     <= 1'b0;
    end else begin
      mem_cs_n <= cs_n_d;
      mem_we_n <= we_n_d;
      mem_doe  <= doe_d;
      done     <= done_nxt;
    end
  end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 4,
  parameter int AS_CYC  = 1,
  parameter int DRV_CYC = 1,
  parameter int WP_CYC  = 2,
  parameter int DV_CYC  = 1,
  parameter int WR_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe
);
  localparam int MAX_A = (AS_CYC > DRV_CYC) ? AS_CYC : DRV_CYC;
  localparam int MAX_B = (WP_CYC > WR_CYC) ? WP_CYC : WR_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  phase_t phase_nxt;
  logic   accept;
  logic   done_nxt;

  sws_fsm #(
    .AS_CYC (AS_CYC),
    .DRV_CYC(DRV_CYC),
    .WP_CYC (WP_CYC),
    .WR_CYC (WR_CYC),
    .CW     (CW)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (wr_req),
    .phase_nxt(phase_nxt),
    .accept   (accept),
    .done_nxt (done_nxt)
  );

  sws_outreg #(.AW(ADDR_W), .DW(DATA_W)) i_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .phase_nxt(phase_nxt),
    .done_nxt (done_nxt),
    .req_addr (wr_addr),
    .req_data (wr_data),
    .mem_addr (mem_addr),
    .mem_dout (mem_dout),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_doe  (mem_doe),
    .done     (wr_done)
  );
endmodule

// File: rtl/sws_chk.sv
module sws_chk #(
  parameter int AW     = 14,
  parameter int DW     = 4,
  parameter int WP_CYC = 2,
  parameter int DV_CYC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_doe,
  input logic          wr_done
);
  logic [15:0] ov_cnt, dv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_cnt <= '0;
      dv_cnt <= '0;
    end else begin
      ov_cnt <= (!mem_cs_n && !mem_we_n) ? ((ov_cnt == 16'hFFFF) ? ov_cnt : ov_cnt + 1'b1) : '0;
      dv_cnt <= mem_doe ? ((dv_cnt == 16'hFFFF) ? dv_cnt : dv_cnt + 1'b1) : '0;
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dout))) else $error("addr moved"); // R2
  AST_CS_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !mem_we_n) else $error("cs low without we"); // R4
  AST_CS_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> $past(!mem_we_n)) else $error("cs fell first"); // R4
  AST_END_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_cs_n)) else $error("strobes split"); // R5
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (ov_cnt == 16'(WP_CYC))) else $error("overlap length"); // R5
  AST_DOE_IN_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> (!mem_cs_n && !mem_we_n)) else $error("drive outside overlap"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done) else $error("done too long"); // R7
  AST_DATA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (dv_cnt >= 16'(DV_CYC))) else $error("data valid short"); // R9
endmodule

bind sram_wr_seq sws_chk #(
  .AW(ADDR_W), .DW(DATA_W), .WP_CYC(WP_CYC), .DV_CYC(DV_CYC)
) i_sws_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_doe(mem_doe), .wr_done(wr_done)
);

// File: tb/test_sram_wr_seq.sv
`timescale 1ns/1ps
module test_sram_wr_seq;
  localparam int AS  = 1;
  localparam int DRV = 1;
  localparam int WP  = 2;
  localparam int DV  = 1;
  localparam int WR  = 1;
  localparam int E   = AS + DRV + WP + WR;

  // vector: {addr[13:0], data[3:0], inject_busy_req, gap[3:0]}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {14'h0000, 4'h5, 1'b0, 4'd2},
    {14'h3FFF, 4'hA, 1'b0, 4'd0},
    {14'h1234, 4'hF, 1'b0, 4'd0},
    {14'h2AAA, 4'h0, 1'b1, 4'd3},
    {14'h1555, 4'h9, 1'b1, 4'd0},
    {14'h0001, 4'h6, 1'b0, 4'd1},
    {14'h2000, 4'h3, 1'b0, 4'd0},
    {14'h0FF0, 4'hC, 1'b1, 4'd2}
  };

  logic        clk, rst_n, wr_req, wr_done;
  logic [13:0] wr_addr, mem_addr;
  logic [3:0]  wr_data, mem_dout;
  logic        mem_cs_n, mem_we_n, mem_doe;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  sram_wr_seq #(.AS_CYC(AS), .DRV_CYC(DRV), .WP_CYC(WP), .DV_CYC(DV), .WR_CYC(WR))
  i_sram_wr_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_doe(mem_doe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // RAM model: latches at the end of the strobe overlap, flags contention
  logic        p_ov, p_doe;
  logic [13:0] p_addr, lat_addr;
  logic [3:0]  p_dout, lat_data;
  logic        lat_doe;
  int          contention = 0;

  always @(negedge clk) begin
    if (p_ov && !(!mem_cs_n && !mem_we_n)) begin
      lat_addr <= p_addr;
      lat_data <= p_dout;
      lat_doe  <= p_doe;
    end
    if (mem_doe && !mem_cs_n && mem_we_n) contention <= contention + 1;
    p_ov   <= !mem_cs_n && !mem_we_n;
    p_addr <= mem_addr;
    p_dout <= mem_dout;
    p_doe  <= mem_doe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_wr(input logic [13:0] a, input logic [3:0] d, input bit inj, input string atag);
    bit lead, pul;
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); #1;
    wr_req = 1'b0; wr_addr = ~a; wr_data = ~d;
    for (int m = 0; m <= E; m++) begin
      if (m > 0) begin @(negedge clk); #1; end
      if (inj && m == 1) wr_req = 1'b1;    // R8 busy request
      if (inj && m == 2) wr_req = 1'b0;
      lead = (m >= AS) && (m < AS + DRV);
      pul  = (m >= AS + DRV) && (m < AS + DRV + WP);
      chk(m == 0 ? atag : (inj ? "R8 addr" : "R2 addr"), mem_addr, a);
      chk(inj ? "R8 data" : "R2 data", mem_dout, d);
      chk("R3 we_n", mem_we_n, !(lead || pul));
      chk("R4/R5 cs_n", mem_cs_n, !pul);
      chk("R6 doe", mem_doe, pul);
      chk("R7 done", wr_done, m == E);
    end
    chk("R5 latched addr", lat_addr, a);
    chk("R5 latched data", lat_data, d);
    chk("R9 driven at end", lat_doe, 1);
    chk("R6 contention", contention, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    wr_req = 0; wr_addr = '0; wr_data = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 doe", mem_doe, 0);
    chk("R1 done", wr_done, 0);
    rst_n = 1;
    @(negedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      run_wr(v[22:9], v[8:5], v[4], (i > 0 && VEC[i-1][3:0] == 0) ? "R10 accept" : "R2 accept");
      for (int g = 0; g < int'(v[3:0]); g++) begin
        @(negedge clk); #1;
        chk("R7 idle done", wr_done, 0);
        chk("R8 idle we_n", mem_we_n, 1);
      end
    end

    // asynchronous reset in the middle of the overlap
    wr_req = 1; wr_addr = 14'h0ABC; wr_data = 4'h7;
    @(posedge clk); @(negedge clk); #1; wr_req = 0;
    repeat (AS + DRV) @(negedge clk);
    #1;
    chk("R6 mid doe", mem_doe, 1);
    rst_n = 0; #1;
    chk("R1 async cs_n", mem_cs_n, 1);
    chk("R1 async we_n", mem_we_n, 1);
    chk("R1 async doe", mem_doe, 0);
    @(negedge clk); #1; rst_n = 1;
    @(negedge clk); #1;
    chk("R1 stays idle", mem_we_n, 1);
    run_wr(14'h0ABD, 4'hE, 1'b0, "R2 after reset");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule